// File: doc/BRIEF.md
# Clear-on-Read Event Counter Bank

This block keeps eleven free-running event counters for an Ethernet MAC. Each cycle the receive and transmit paths raise single-cycle strobes for the events they see: frame check failures, receive errors, single and excessive collisions, and the good, broadcast, multicast and total frame counts in both directions. Each strobe adds one to its own counter. Software reaches the counters through a read-only register window that spans 4 KiB. Each counter sits at a fixed, sparse word offset, and every other word in the window reads as zero.

A read is a valid/ready request carrying a byte address, followed by a valid/ready response carrying the count. The request is accepted when `req_valid` and `req_ready` are both high. In that same cycle the addressed counter is captured into the response register and cleared, so no event is lost and none is counted twice. The response register holds one entry. `req_ready` is high whenever that register is empty or is being drained, so a stalled response holds back new requests. Initialisation software can zero the whole bank by reading every word of the window once.

Top module: `stats_bank`

## Requirements
- R1: After reset every counter is zero, `rsp_valid` is low and `req_ready` is high.
- R2: Strobe bit `ev[i]` adds exactly one to counter i in every cycle it is high, independently of the other bits. The bit order is: 0 frame check error, 1 receive error, 2 single collision, 3 excessive collision, 4 good frame received, 5 broadcast received, 6 multicast received, 7 total received, 8 total transmitted, 9 multicast transmitted, 10 broadcast transmitted.
- R3: The window covers byte addresses 0x4000 to 0x4FFF, and address bits [1:0] are ignored. Counter i sits at byte offset 0x000, 0x00C, 0x014, 0x018, 0x074, 0x078, 0x07C, 0x0D0, 0x0D4, 0x0F0 or 0x0F4 from the window base, for i = 0 to 10 in that order.
- R4: An accepted read of a mapped address returns the counter's value and leaves the counter at zero.
- R5: If a strobe and an accepted read hit the same counter in one cycle, the read returns the value before the increment and the counter is left at 1.
- R6: Counters wrap modulo 2^CNT_W, which is 2^32 by default.
- R7: An accepted read of an unmapped word, inside or outside the window, returns zero and changes no counter.
- R8: `req_ready` equals `!rsp_valid || rsp_ready`. The response is valid in the cycle after acceptance. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` hold steady and no request is accepted.
- R9: Reading every word offset of the window once, with no strobes active, leaves all counters at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev | input | 11 | Event strobes, one per counter |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Read request accepted when high with req_valid |
| req_addr | input | ADDR_W (16) | Byte address of the read |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | CNT_W (32) | Returned counter value |

## Verification
A strobe driven before a rising edge shows up in its counter after that edge. A request accepted at an edge produces `rsp_valid` and `rsp_data` one edge later, and the counter is cleared at that same edge. `req_ready` is combinational, so it is compared within the cycle in which the stimulus is driven. The bench drives inputs just after each falling edge and updates its reference model as of the next rising edge. It compares the registered outputs at the falling edge that follows, exactly one register stage after acceptance, and keeps the expected response pending for as long as back-pressure stalls it.

// File: rtl/stats_pkg.sv
package stats_pkg;
  localparam int NUM_CTR   = 11;
  localparam int WIN_BYTES = 4096;
  localparam int WIN_LSB   = $clog2(WIN_BYTES);
  localparam int WORD_W    = WIN_LSB - 2;

  typedef logic [WORD_W-1:0] word_ofs_t;

  // Word offset of each counter inside the window; index matches event bit.
  localparam word_ofs_t CTR_WORD [NUM_CTR] = '{
    10'h000, 10'h003, 10'h005, 10'h006, 10'h01D, 10'h01E,
    10'h01F, 10'h034, 10'h035, 10'h03C, 10'h03D
  };
endpackage

// File: rtl/stats_addr_decode.sv
module stats_addr_decode
  import stats_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h4000
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_CTR-1:0] sel,
  output logic               hit
);
  logic       in_win;
  word_ofs_t  word;
  logic       unused_lo;

  assign in_win    = addr[ADDR_W-1:WIN_LSB] == WIN_BASE[ADDR_W-1:WIN_LSB];
  assign word      = addr[WIN_LSB-1:2];
  assign unused_lo = ^addr[1:0];

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_match
    assign sel[i] = in_win && (word == CTR_WORD[i]);
  end

  assign hit = |sel;
endmodule

// File: rtl/stats_counter.sv
module stats_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  logic [W-1:0] base;

  // A clearing read restarts from zero; a coincident event still counts.
  assign base = clr ? '0 : cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (inc || clr) cnt <= base + W'(inc);
  end
endmodule

// File: rtl/stats_read_mux.sv
module stats_read_mux #(
  parameter int W = 32,
  parameter int N = 11
) (
  input  logic [N-1:0]        sel,
  input  logic [N-1:0][W-1:0] cnt,
  output logic [W-1:0]        data
);
  always_comb begin
    data = '0;
    for (int i = 0; i < N; i++) begin
      data = data | (cnt[i] & {W{sel[i]}});
    end
  end
endmodule

// File: rtl/stats_bank.sv
module stats_bank
  import stats_pkg::*;
#(
  parameter int                CNT_W    = 32,
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h4000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CTR-1:0] ev,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [CNT_W-1:0]   rsp_data
);
  logic [NUM_CTR-1:0]            sel;
  logic                          hit;
  logic                          accept;
  logic [NUM_CTR-1:0][CNT_W-1:0] cnt;
  logic [CNT_W-1:0]              rd_val;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  stats_addr_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_dec (
    .addr (req_addr),
    .sel  (sel),
    .hit  (hit)
  );

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    stats_counter #(.W(CNT_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (ev[i]),
      .clr   (accept && sel[i]),
      .cnt   (cnt[i])
    );
  end

  stats_read_mux #(.W(CNT_W), .N(NUM_CTR)) u_mux (
    .sel  (sel),
    .cnt  (cnt),
    .data (rd_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_val;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/stats_bank_chk.sv
module stats_bank_chk
  import stats_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_CTR-1:0]            ev,
  input logic                          req_valid,
  input logic                          req_ready,
  input logic                          rsp_valid,
  input logic                          rsp_ready,
  input logic [CNT_W-1:0]              rsp_data,
  input logic [NUM_CTR-1:0]            sel,
  input logic                          hit,
  input logic [NUM_CTR-1:0][CNT_W-1:0] cnt
);
  logic acc;
  assign acc = req_valid && req_ready;

  assert_one_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

  assert_rsp_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);

  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_stall_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !hit) |=> (rsp_data == '0));

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr_chk
    assert_count_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ev[i] && !(acc && sel[i])) |=> (cnt[i] == CNT_W'($past(cnt[i]) + 1'b1)));

    assert_clear_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && sel[i] && !ev[i]) |=> (cnt[i] == '0));

    assert_collide_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && sel[i] && ev[i]) |=> (cnt[i] == CNT_W'(1)));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev[i] && !(acc && sel[i])) |=> $stable(cnt[i]));
  end
endmodule

bind stats_bank stats_bank_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ev        (ev),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .sel       (sel),
  .hit       (hit),
  .cnt       (cnt)
);

// File: tb/stats_bank_test.sv
`timescale 1ns/1ps
module stats_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] ev = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;

  logic [10:0] n_ev = '0;
  logic        n_req_valid = 1'b0;
  logic        n_req_ready;
  logic [15:0] n_req_addr = '0;
  logic        n_rsp_valid;
  logic [7:0]  n_rsp_data;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] model [11];
  logic        m_vld = 1'b0;
  logic [31:0] m_data = '0;
  string       m_tag = "R4";

  always #2.5 clk = ~clk;

  stats_bank uut (
    .clk(clk), .rst_n(rst_n), .ev(ev), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  stats_bank #(.CNT_W(8)) uut_narrow (
    .clk(clk), .rst_n(rst_n), .ev(n_ev), .req_valid(n_req_valid), .req_ready(n_req_ready),
    .req_addr(n_req_addr), .rsp_valid(n_rsp_valid), .rsp_ready(1'b1), .rsp_data(n_rsp_data)
  );

  function automatic int idx_of(logic [15:0] a);
    if (a[15:12] != 4'h4) return -1;
    case ({a[11:2], 2'b00})
      12'h000: return 0;
      12'h00C: return 1;
      12'h014: return 2;
      12'h018: return 3;
      12'h074: return 4;
      12'h078: return 5;
      12'h07C: return 6;
      12'h0D0: return 7;
      12'h0D4: return 8;
      12'h0F0: return 9;
      12'h0F4: return 10;
      default: return -1;
    endcase
  endfunction

  function automatic logic [15:0] addr_of(int k);
    logic [11:0] o [11] = '{12'h000, 12'h00C, 12'h014, 12'h018, 12'h074, 12'h078,
                            12'h07C, 12'h0D0, 12'h0D4, 12'h0F0, 12'h0F4};
    return {4'h4, o[k]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [10:0] e, input logic v, input logic [15:0] a,
                      input logic r, input string tag);
    bit acc;
    int k;
    @(negedge clk);
    chk(rsp_valid == m_vld, "R8 rsp_valid", 32'(rsp_valid), 32'(m_vld));
    if (m_vld) chk(rsp_data == m_data, m_tag, rsp_data, m_data);
    ev = e; req_valid = v; req_addr = a; rsp_ready = r;
    #1;
    chk(req_ready == (!m_vld || r), "R8 req_ready", 32'(req_ready), 32'(!m_vld || r));
    acc = v && (!m_vld || r);
    k = idx_of(a);
    if (acc) begin
      m_vld = 1'b1;
      m_data = (k >= 0) ? model[k] : 32'h0;
      m_tag = tag;
      if (k >= 0) model[k] = '0;
    end else if (r) begin
      m_vld = 1'b0;
    end
    for (int i = 0; i < 11; i++) if (e[i]) model[i] = model[i] + 1;
  endtask

  task automatic read_all(input string tag);
    for (int k = 0; k < 11; k++) step('0, 1'b1, addr_of(k), 1'b1, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 11; i++) model[i] = '0;
    void'($urandom(32'd7331));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 1);
    read_all("R1");
    // R2: single bit and all bits
    for (int n = 0; n < 5; n++) step(11'h010, 1'b0, '0, 1'b1, "R2");
    step(11'h7FF, 1'b0, '0, 1'b1, "R2");
    step(11'h7FF, 1'b0, '0, 1'b1, "R2");
    step(11'h401, 1'b0, '0, 1'b1, "R2");
    read_all("R2");
    // R3: low address bits ignored
    step(11'h020, 1'b0, '0, 1'b1, "R3");
    step('0, 1'b1, 16'h407B, 1'b1, "R3");
    step('0, 1'b1, 16'h4078, 1'b1, "R3");
    // R5: coincident strobe and read
    for (int n = 0; n < 4; n++) step(11'h001, 1'b0, '0, 1'b1, "R5");
    step(11'h001, 1'b1, 16'h4000, 1'b1, "R5");
    step('0, 1'b1, 16'h4000, 1'b1, "R5");
    // R7: unmapped reads
    for (int n = 0; n < 3; n++) step(11'h020, 1'b0, '0, 1'b1, "R7");
    step('0, 1'b1, 16'h4004, 1'b1, "R7");
    step('0, 1'b1, 16'h5078, 1'b1, "R7");
    step('0, 1'b1, 16'h4FFC, 1'b1, "R7");
    step('0, 1'b1, 16'h4078, 1'b1, "R7");
    // R8: back-pressure
    step(11'h100, 1'b0, '0, 1'b1, "R8");
    step(11'h100, 1'b0, '0, 1'b1, "R8");
    step(11'h080, 1'b1, 16'h40D4, 1'b0, "R8");
    step('0, 1'b0, '0, 1'b0, "R8");
    step('0, 1'b1, 16'h40D0, 1'b0, "R8");
    step('0, 1'b0, '0, 1'b1, "R8");
    step('0, 1'b1, 16'h40D0, 1'b1, "R8");
    step('0, 1'b0, '0, 1'b1, "R8");
    // Random traffic checked against the model (R2, R4)
    for (int n = 0; n < 3000; n++) begin
      logic [10:0] e;
      logic [15:0] a;
      int pick;
      e = '0;
      for (int b = 0; b < 11; b++) e[b] = ($urandom % 4) == 0;
      pick = $urandom % 10;
      if (pick < 6)      a = addr_of($urandom % 11);
      else if (pick < 8) a = {4'h4, 12'($urandom)};
      else               a = 16'($urandom);
      step(e, ($urandom % 2) == 1, a, ($urandom % 5) != 0, "R4");
    end
    // R9: sweep of the whole window
    for (int w = 0; w < 1024; w++) step('0, 1'b1, 16'h4000 + 16'(w * 4), 1'b1, "R9");
    read_all("R9");
    step('0, 1'b0, '0, 1'b1, "R9");
    step('0, 1'b0, '0, 1'b1, "R9");
    // R6: wrap on the 8-bit instance after 300 events
    @(negedge clk) n_ev = 11'h001;
    repeat (300) @(negedge clk);
    n_ev = '0;
    n_req_valid = 1'b1; n_req_addr = 16'h4000;
    @(negedge clk) n_req_valid = 1'b0;
    chk(n_rsp_valid == 1'b1, "R6 valid", 32'(n_rsp_valid), 1);
    chk(n_rsp_data == 8'd44, "R6 wrap", 32'(n_rsp_data), 44);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule